// File: doc/BRIEF.md
# DMA Channel Arm and Abort Controller

This block keeps the enable ("armed") state of five DMA channels and follows how far each channel has got through its transfer. Software writes a single byte register. A write with the top bit clear loads a new arm pattern. A write with the top bit set aborts the channels whose low bits are written as one. A data mover reports each finished byte or word with a one-cycle strobe on that channel's line and places the unit's value on a shared data bus. The block answers with a per-channel transfer enable and a completion interrupt.

Each channel has its own configuration.

- Fixed-length mode takes the unit count from a configuration field.
- Variable-length mode reads the count from the first unit the channel moves. In byte mode that count is either the whole byte or its low seven bits. In word mode all eight bits are used.

When a channel reaches its count, its progress is reset. In one-shot mode its arm bit is also cleared. In repeating mode the channel stays armed and starts the next block.

Top module: `dma_arm_ctrl`

## Requirements
- R1: After reset all arm bits are 0, the register read value is 0x00, every transfer enable is 0 and every interrupt is 0.
- R2: A register write with bit 7 = 0 loads bits 4:0 as the new arm state (bit n arms channel n). The read value always has bits 7:5 equal to 0 and shows the arm state in bits 4:0.
- R3: The transfer enable of a channel equals its arm bit. A strobe on a channel that is not armed has no effect: it raises no interrupt and adds nothing to that channel's progress.
- R4: In fixed-length mode a channel completes on its N-th accepted strobe, where N is its length field. A length of 0 behaves as 1. In one-shot mode the arm bit is 0 from the cycle after completion.
- R5: In repeating mode a channel stays armed after completion, its count restarts, and it completes again after another full block.
- R6: On completion, the channel's interrupt is 1 for exactly the one cycle after the completing strobe, but only when that channel's interrupt enable is 1. When the enable is 0, no interrupt is raised.
- R7: A register write with bit 7 = 1 clears the arm bit of each channel whose bit in 4:0 is 1. The arm bits of the other channels are left unchanged.
- R8: An aborted channel loses its progress. When armed again it needs a full block to complete. A strobe in the same cycle as its abort raises no interrupt.
- R9: In variable-length byte mode the first accepted strobe carries the length on the data bus and is not counted as a unit. With the 7-bit select at 0 the length is all 8 bits. With the select at 1 the length is bits 6:0.
- R10: In variable-length word mode the 7-bit select is ignored and all 8 bits of the first unit give the length.
- R11: A variable length that decodes to 0 completes the channel on the length unit itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Arm register write strobe |
| reg_wdata | input | 8 | Write data: bit 7 selects abort, bits 4:0 are per-channel |
| reg_rdata | output | 8 | Arm register read value |
| cfg_irq_en | input | 5 | Per-channel interrupt enable |
| cfg_repeat | input | 5 | Per-channel repeating mode |
| cfg_var_len | input | 5 | Per-channel variable-length mode |
| cfg_word | input | 5 | Per-channel word unit size (1) or byte (0) |
| cfg_len7 | input | 5 | Per-channel 7-bit length select in variable byte mode |
| cfg_len_fixed | input | 50 | Per-channel fixed length, 10 bits each, channel 0 in the low bits |
| xfer_strobe | input | 5 | One-cycle unit-done strobe per channel, at most one set |
| xfer_data | input | 8 | Value of the unit being moved |
| xfer_en | output | 5 | Per-channel transfer permission |
| irq | output | 5 | Per-channel completion interrupt pulse |

## Verification
Two cases are hard to reach from the ports. The first is an abort that lands in the very cycle of a channel's final strobe. The bench counts strobes up to one short of the length, then drives the abort write and the last strobe on the same clock edge, and checks that no interrupt appears and that the arm bit is clear. The second is the variable-length decode. The bench uses length bytes with bit 7 set, so the 7-bit and 8-bit interpretations give very different counts, and a value whose low seven bits are zero, which must complete on the length unit itself.

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;

    localparam int REG_W     = 8;
    localparam int ABORT_POS = 7;

    // Length carried by the first unit of a variable-length channel.
    function automatic logic [7:0] first_unit_len(
        input logic       word_mode,
        input logic       low7,
        input logic [7:0] unit
    );
        if (!word_mode && low7)
            return {1'b0, unit[6:0]};
        return unit;
    endfunction

endpackage

// File: rtl/dma_arm_reg.sv
module dma_arm_reg
    import dma_arm_pkg::*;
#(
    parameter int NCH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [NCH-1:0]   done_i,
    input  logic [NCH-1:0]   rpt_i,
    output logic [NCH-1:0]   arm_o,
    output logic [NCH-1:0]   abort_o,
    output logic [REG_W-1:0] rdata_o
);

    typedef struct packed {
        logic [NCH-1:0] arm;
    } arm_state_t;

    arm_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        abort_o = '0;
        if (wr_i && wdata_i[ABORT_POS])
            abort_o = wdata_i[NCH-1:0];
        // one-shot channels drop out at completion
        st_d.arm = st_q.arm & ~(done_i & ~rpt_i);
        st_d.arm = st_d.arm & ~abort_o;
        if (wr_i && !wdata_i[ABORT_POS])
            st_d.arm = wdata_i[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign arm_o   = st_q.arm;
    assign rdata_o = {{(REG_W-NCH){1'b0}}, st_q.arm};

    a_r2_load_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[ABORT_POS]) |=> (arm_o == $past(wdata_i[NCH-1:0])));

    a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[ABORT_POS]) |=> ((arm_o & $past(wdata_i[NCH-1:0])) == '0));

    a_r7_abort_arms_none: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[ABORT_POS]) |=> ((arm_o & ~$past(arm_o)) == '0));

    a_r5_repeat_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && ((done_i & rpt_i) != '0)) |=> ((arm_o & $past(done_i & rpt_i)) == $past(done_i & rpt_i)));

endmodule

// File: rtl/dma_arm_chan.sv
module dma_arm_chan
    import dma_arm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             abort_i,
    input  logic             strobe_i,
    input  logic [7:0]       data_i,
    input  logic             var_i,
    input  logic             word_i,
    input  logic             low7_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);

    typedef struct packed {
        logic             have_len;
        logic [CNT_W-1:0] tgt;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    chan_state_t      st_d, st_q;
    logic [CNT_W-1:0] var_len;
    logic [CNT_W-1:0] goal;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        done_o  = 1'b0;
        var_len = CNT_W'(first_unit_len(word_i, low7_i, data_i));
        goal    = var_i ? st_q.tgt : len_i;
        cnt_inc = st_q.cnt + 1'b1;
        if (!arm_i || abort_i) begin
            st_d = '0;
        end else if (strobe_i) begin
            if (var_i && !st_q.have_len) begin
                if (var_len == '0) begin
                    done_o = 1'b1;
                    st_d   = '0;
                end else begin
                    st_d.have_len = 1'b1;
                    st_d.tgt      = var_len;
                    st_d.cnt      = '0;
                end
            end else if (cnt_inc >= goal) begin
                done_o = 1'b1;
                st_d   = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    a_r3_idle_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i) |=> (st_q == '0));

    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.have_len |-> (st_q.tgt != '0));

    a_r9_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.have_len |-> (st_q.cnt < st_q.tgt));

    a_r8_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !done_o);

endmodule

// File: rtl/dma_arm_irq.sv
module dma_arm_irq #(
    parameter int NCH = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done_i,
    input  logic [NCH-1:0] en_i,
    output logic [NCH-1:0] irq_o
);

    typedef struct packed {
        logic [NCH-1:0] irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = done_i & en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    a_r6_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~$past(done_i)) == '0));

endmodule

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl
    import dma_arm_pkg::*;
#(
    parameter int NCH   = 5,
    parameter int CNT_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NCH-1:0]       cfg_irq_en,
    input  logic [NCH-1:0]       cfg_repeat,
    input  logic [NCH-1:0]       cfg_var_len,
    input  logic [NCH-1:0]       cfg_word,
    input  logic [NCH-1:0]       cfg_len7,
    input  logic [NCH*CNT_W-1:0] cfg_len_fixed,
    input  logic [NCH-1:0]       xfer_strobe,
    input  logic [7:0]           xfer_data,
    output logic [NCH-1:0]       xfer_en,
    output logic [NCH-1:0]       irq
);

    logic [NCH-1:0] arm;
    logic [NCH-1:0] abort_mask;
    logic [NCH-1:0] done;

    dma_arm_reg #(.NCH(NCH)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .done_i  (done),
        .rpt_i   (cfg_repeat),
        .arm_o   (arm),
        .abort_o (abort_mask),
        .rdata_o (reg_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dma_arm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm[c]),
            .abort_i  (abort_mask[c]),
            .strobe_i (xfer_strobe[c]),
            .data_i   (xfer_data),
            .var_i    (cfg_var_len[c]),
            .word_i   (cfg_word[c]),
            .low7_i   (cfg_len7[c]),
            .len_i    (cfg_len_fixed[c*CNT_W +: CNT_W]),
            .done_o   (done[c])
        );
    end

    dma_arm_irq #(.NCH(NCH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done),
        .en_i   (cfg_irq_en),
        .irq_o  (irq)
    );

    assign xfer_en = arm;

    a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_strobe));

    a_r8_abort_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[7]) |=> ((irq & $past(reg_wdata[NCH-1:0])) == '0));

    a_r2_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[7]) |=> (reg_rdata[7:NCH] == '0 && reg_rdata[NCH-1:0] == $past(reg_wdata[NCH-1:0])));

endmodule

// File: tb/tb_dma_arm_ctrl.sv
module tb_dma_arm_ctrl;

    localparam int NCH   = 5;
    localparam int CNT_W = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_wr = 1'b0;
    logic [7:0]           reg_wdata = '0;
    logic [7:0]           reg_rdata;
    logic [NCH-1:0]       cfg_irq_en = '1;
    logic [NCH-1:0]       cfg_repeat = '0;
    logic [NCH-1:0]       cfg_var_len = '0;
    logic [NCH-1:0]       cfg_word = '0;
    logic [NCH-1:0]       cfg_len7 = '0;
    logic [NCH*CNT_W-1:0] cfg_len_fixed = '0;
    logic [NCH-1:0]       xfer_strobe = '0;
    logic [7:0]           xfer_data = '0;
    logic [NCH-1:0]       xfer_en;
    logic [NCH-1:0]       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dma_arm_ctrl #(.NCH(NCH), .CNT_W(CNT_W)) dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic strobe(input int ch, input logic [7:0] d);
        @(negedge clk);
        xfer_strobe = '0; xfer_strobe[ch] = 1'b1; xfer_data = d;
        @(negedge clk);
        xfer_strobe = '0; xfer_data = '0;
    endtask

    task automatic set_len(input int ch, input int len);
        cfg_len_fixed[ch*CNT_W +: CNT_W] = CNT_W'(len);
    endtask

    // n strobes: none but the last may complete; the last raises irq if exp_irq
    task automatic run_block(input string tag, input int ch, input int n, input logic exp_irq);
        for (int i = 0; i < n - 1; i++) begin
            strobe(ch, 8'h00);
            if (irq[ch] !== 1'b0 || xfer_en[ch] !== 1'b1) begin
                chk({tag, " early"}, {irq[ch], xfer_en[ch]}, 2'b01);
                return;
            end
        end
        strobe(ch, 8'h00);
        chk({tag, " irq at end"}, irq[ch], exp_irq);
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 xfer_en", xfer_en, '0);
        chk("R1 irq", irq, '0);
    endtask

    task automatic t_load_read();
        wr_reg(8'h6A);
        chk("R2 rdata masks 7:5", reg_rdata, 8'h0A);
        chk("R3 xfer_en follows arm", xfer_en, 5'h0A);
        wr_reg(8'h15);
        chk("R2 reload", reg_rdata, 8'h15);
        wr_reg(8'h00);
        chk("R2 clear", reg_rdata, 8'h00);
    endtask

    task automatic t_fixed();
        set_len(0, 4);
        wr_reg(8'h01);
        run_block("R4 fixed len4", 0, 4, 1'b1);
        chk("R4 one-shot disarm", xfer_en[0], 1'b0);
        @(negedge clk);
        chk("R6 irq one cycle", irq[0], 1'b0);
        set_len(0, 0);
        wr_reg(8'h01);
        strobe(0, 8'h00);
        chk("R4 len0 as 1", {irq[0], xfer_en[0]}, 2'b10);
    endtask

    task automatic t_ignored();
        set_len(1, 4);
        for (int i = 0; i < 3; i++) strobe(1, 8'h00);
        chk("R3 unarmed no irq", irq, '0);
        wr_reg(8'h02);
        run_block("R3 no progress while unarmed", 1, 4, 1'b1);
    endtask

    task automatic t_masked();
        set_len(2, 2);
        cfg_irq_en[2] = 1'b0;
        wr_reg(8'h04);
        run_block("R6 masked", 2, 2, 1'b0);
        chk("R6 masked still disarms", xfer_en[2], 1'b0);
        cfg_irq_en[2] = 1'b1;
    endtask

    task automatic t_repeat();
        set_len(3, 2);
        cfg_repeat[3] = 1'b1;
        wr_reg(8'h08);
        run_block("R5 first block", 3, 2, 1'b1);
        chk("R5 stays armed", xfer_en[3], 1'b1);
        run_block("R5 second block", 3, 2, 1'b1);
        wr_reg(8'h00);
        cfg_repeat[3] = 1'b0;
    endtask

    task automatic t_abort();
        wr_reg(8'h1F);
        wr_reg(8'h85);
        chk("R7 selected aborted", reg_rdata, 8'h1A);
        set_len(0, 4);
        wr_reg(8'h01);
        strobe(0, 8'h00);
        strobe(0, 8'h00);
        wr_reg(8'h81);
        chk("R8 abort disarms", xfer_en[0], 1'b0);
        wr_reg(8'h01);
        run_block("R8 full block after abort", 0, 4, 1'b1);
        wr_reg(8'h01);
        for (int i = 0; i < 3; i++) strobe(0, 8'h00);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h81;
        xfer_strobe = 5'h01;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; xfer_strobe = '0;
        chk("R8 abort beats final strobe", {irq[0], xfer_en[0]}, 2'b00);
    endtask

    task automatic t_var_byte();
        cfg_var_len[4] = 1'b1;
        cfg_len7[4] = 1'b1;
        wr_reg(8'h10);
        strobe(4, 8'h83);
        chk("R9 length unit not counted", irq[4], 1'b0);
        run_block("R9 7-bit length 3", 4, 3, 1'b1);
        cfg_len7[4] = 1'b0;
        wr_reg(8'h10);
        strobe(4, 8'h83);
        run_block("R9 8-bit length 131", 4, 131, 1'b1);
    endtask

    task automatic t_var_word();
        cfg_word[4] = 1'b1;
        cfg_len7[4] = 1'b1;
        wr_reg(8'h10);
        strobe(4, 8'h82);
        run_block("R10 word ignores 7-bit select", 4, 130, 1'b1);
        cfg_word[4] = 1'b0;
    endtask

    task automatic t_var_zero();
        cfg_len7[4] = 1'b1;
        wr_reg(8'h10);
        strobe(4, 8'h80);
        chk("R11 zero len completes", {irq[4], xfer_en[4]}, 2'b10);
        cfg_len7[4] = 1'b0;
        wr_reg(8'h10);
        strobe(4, 8'h00);
        chk("R11 zero byte completes", {irq[4], xfer_en[4]}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_fixed();
        t_ignored();
        t_masked();
        t_repeat();
        t_abort();
        t_var_byte();
        t_var_word();
        t_var_zero();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule